// File: doc/BRIEF.md
# Low-power mode controller

This block sequences the operating mode of a small microcontroller core. After reset it runs in the full-rate state. A speed input moves it between full rate and reduced rate. A sleep-instruction strobe moves it into one of the low-power states or into the subclock-driven state. A wake input brings it back from the light low-power states. Two flags in an 8-bit control register decide which targets a sleep strobe may reach. A "direct" flag permits a jump between the full-rate and subclock states without first waking the CPU. A "slow" flag makes the subclock state the home mode: watch exits into it, and the sleep strobe may reach it.

The controller drives a one-hot mode vector. It also drives a CPU clock enable: high on every cycle in the full-rate and reduced-rate states, and a pulse divided from a subclock tick in the subclock state. A third output is a sampling strobe for a noise filter, divided from the main clock. All outputs are single-cycle enables, not generated clocks. The control register is written and read over a plain one-register bus.

States (one-hot bit index in brackets): HIGH [0] full rate, MED [1] reduced rate, SUB [2] subclock, SLEEP [3], SUBSLEEP [4], STBY [5] standby, WATCH [6]. Transitions: HIGH to MED and back (speed input), sleep entry from HIGH, MED and SUB, wake exit from SLEEP, SUBSLEEP and WATCH, and reset as the only exit from STBY.

Top module: `pwrmode_ctrl`

## Requirements
- R1: The control register holds xfer_direct at bit 7, low_speed at bit 6, nf_fast at bit 5 and sub_sel at bits 1:0. All of these reset to 0 and read back what was written on the cycle after the write. Bits 4:2 always read 0.
- R2: Reset (synchronous, active high) puts the controller in HIGH. mode_oh always has exactly one bit set, at the index of the current state: HIGH 0, MED 1, SUB 2, SLEEP 3, SUBSLEEP 4, STBY 5, WATCH 6.
- R3: With no sleep strobe, HIGH moves to MED while speed_med is 1, and MED moves to HIGH while speed_med is 0.
- R4: A sleep strobe in HIGH or MED with stby_sel=1 enters WATCH when watch_en=1 and the two flags are not both 1. Otherwise it enters STBY.
- R5: A sleep strobe in HIGH or MED with stby_sel=0 enters SUB when direct_ok=1, low_speed=1 and either xfer_direct=1 or the state is HIGH. Otherwise it enters SLEEP.
- R6: A sleep strobe in SUB behaves as follows. With both flags 1, it enters HIGH if direct_ok=1, else SUBSLEEP, and stby_sel has no effect. With only low_speed set, it enters WATCH if stby_sel=1, else SUBSLEEP. With low_speed 0, it enters WATCH if stby_sel=1, else HIGH if direct_ok=1, else WATCH.
- R7: A wake in SLEEP returns to the state (HIGH or MED) that entered SLEEP. A wake in SUBSLEEP returns to SUB.
- R8: A wake in WATCH enters SUB when low_speed=1 and HIGH when low_speed=0.
- R9: STBY ignores wake. Only reset leaves it.
- R10: A sleep strobe in a low-power state has no effect. A wake in HIGH, MED or SUB has no effect.
- R11: cpu_clk_en is 1 on every cycle in HIGH and MED. In SUB it pulses on every 8th sub_tick when sub_sel=00, every 4th when sub_sel=01, and every 2nd when sub_sel[1]=1. In all other states it is 0.
- R12: nf_sample pulses for one cycle in every 16 main-clock cycles when nf_fast=0, and in every 4 when nf_fast=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main clock |
| rst | input | 1 | Synchronous reset, active high |
| reg_wr | input | 1 | Control register write strobe |
| reg_wdata | input | 8 | Control register write data |
| reg_rdata | output | 8 | Control register read data |
| sleep_req | input | 1 | Sleep-instruction strobe |
| stby_sel | input | 1 | Selects standby or watch as the sleep target |
| watch_en | input | 1 | Watch timer enabled; turns a standby choice into watch |
| direct_ok | input | 1 | Permits the direct transfer between HIGH and SUB |
| speed_med | input | 1 | Selects reduced-rate operation while active |
| wake | input | 1 | Wake event |
| sub_tick | input | 1 | One-cycle tick from the subclock domain |
| mode_oh | output | 7 | One-hot current state |
| cpu_clk_en | output | 1 | CPU clock enable |
| nf_sample | output | 1 | Noise-filter sampling strobe |

## Verification
On every cycle the assertions check the following: the one-hot mode vector, that STBY holds, the return path from SLEEP and SUBSLEEP, that a low-power state stays put without a wake, that the clock enable stays low outside the running states, that the noise strobe lasts one cycle, and that a register write reads back. The sleep-target decision depends on the flags, the state and three select inputs, and the bench sweeps all of these. The bench also covers the exit from WATCH and the division ratios. The ratios are measured as pulse counts over fixed windows, which only a scenario can show.

// File: rtl/pwrmode_pkg.sv
package pwrmode_pkg;

    localparam int NUM_MODES = 7;

    typedef enum logic [2:0] {
        MD_HIGH     = 3'd0,
        MD_MED      = 3'd1,
        MD_SUB      = 3'd2,
        MD_SLEEP    = 3'd3,
        MD_SUBSLEEP = 3'd4,
        MD_STBY     = 3'd5,
        MD_WATCH    = 3'd6
    } pmode_e;

    typedef struct packed {
        logic       xfer_direct;
        logic       low_speed;
        logic       nf_fast;
        logic [1:0] sub_sel;
    } ctl_t;

    // Target state chosen by a sleep strobe in an active state
    function automatic pmode_e sleep_target(
        input pmode_e cur,
        input logic   xd,
        input logic   ls,
        input logic   sb,
        input logic   we,
        input logic   dk
    );
        logic both;
        both = xd & ls;
        if (cur == MD_SUB) begin
            if (sb && !both)
                return MD_WATCH;
            if (dk && (xd || !ls))
                return MD_HIGH;
            if (ls)
                return MD_SUBSLEEP;
            return MD_WATCH;
        end
        if (sb)
            return (we && !both) ? MD_WATCH : MD_STBY;
        if (dk && ls && (xd || cur == MD_HIGH))
            return MD_SUB;
        return MD_SLEEP;
    endfunction

endpackage

// File: rtl/pwrmode_regs.sv
module pwrmode_regs
    import pwrmode_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata,
    output ctl_t          ctl
);
    localparam int BIT_XD = DW - 1;
    localparam int BIT_LS = DW - 2;
    localparam int BIT_NF = DW - 3;

    ctl_t ctl_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q <= '0;
        end else if (wr) begin
            ctl_q.xfer_direct <= wdata[BIT_XD];
            ctl_q.low_speed   <= wdata[BIT_LS];
            ctl_q.nf_fast     <= wdata[BIT_NF];
            ctl_q.sub_sel     <= wdata[1:0];
        end
    end

    always_comb begin
        rdata         = '0;
        rdata[BIT_XD] = ctl_q.xfer_direct;
        rdata[BIT_LS] = ctl_q.low_speed;
        rdata[BIT_NF] = ctl_q.nf_fast;
        rdata[1:0]    = ctl_q.sub_sel;
    end

    assign ctl = ctl_q;

endmodule

// File: rtl/pwrmode_div.sv
module pwrmode_div #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tick,
    input  logic [W-1:0] mask,
    output logic         hit
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (tick)
            cnt <= cnt + W'(1);
    end

    assign hit = tick && ((cnt & mask) == mask);

endmodule

// File: rtl/pwrmode_fsm.sv
module pwrmode_fsm
    import pwrmode_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 xfer_direct,
    input  logic                 low_speed,
    input  logic                 sleep_req,
    input  logic                 stby_sel,
    input  logic                 watch_en,
    input  logic                 direct_ok,
    input  logic                 speed_med,
    input  logic                 wake,
    output logic [NUM_MODES-1:0] mode_oh,
    output logic                 run_full,
    output logic                 run_sub
);
    pmode_e state, state_nxt;
    logic   ret_med, ret_med_nxt;
    logic   low_pwr;

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= MD_HIGH;
            ret_med <= 1'b0;
        end else begin
            state   <= state_nxt;
            ret_med <= ret_med_nxt;
        end
    end

    // Next-state decision
    always_comb begin
        state_nxt   = state;
        ret_med_nxt = ret_med;
        unique case (state)
            MD_HIGH: begin
                if (sleep_req) begin
                    state_nxt   = sleep_target(state, xfer_direct, low_speed,
                                               stby_sel, watch_en, direct_ok);
                    ret_med_nxt = 1'b0;
                end else if (speed_med) begin
                    state_nxt = MD_MED;
                end
            end
            MD_MED: begin
                if (sleep_req) begin
                    state_nxt   = sleep_target(state, xfer_direct, low_speed,
                                               stby_sel, watch_en, direct_ok);
                    ret_med_nxt = 1'b1;
                end else if (!speed_med) begin
                    state_nxt = MD_HIGH;
                end
            end
            MD_SUB: begin
                if (sleep_req)
                    state_nxt = sleep_target(state, xfer_direct, low_speed,
                                             stby_sel, watch_en, direct_ok);
            end
            MD_SLEEP: begin
                if (wake)
                    state_nxt = ret_med ? MD_MED : MD_HIGH;
            end
            MD_SUBSLEEP: begin
                if (wake)
                    state_nxt = MD_SUB;
            end
            MD_WATCH: begin
                if (wake)
                    state_nxt = low_speed ? MD_SUB : MD_HIGH;
            end
            MD_STBY: begin
                state_nxt = MD_STBY;
            end
            default: begin
                state_nxt = MD_HIGH;
            end
        endcase
    end

    // Outputs
    always_comb begin
        mode_oh        = '0;
        mode_oh[state] = 1'b1;
        run_full       = (state == MD_HIGH) || (state == MD_MED);
        run_sub        = (state == MD_SUB);
        low_pwr        = !(run_full || run_sub);
    end

    AST_MODE_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $countones(mode_oh) == 1); // R2
    AST_STBY_LATCH: assert property (@(posedge clk) disable iff (rst)
        mode_oh[MD_STBY] |=> mode_oh[MD_STBY]); // R9
    AST_SLEEP_RETURN: assert property (@(posedge clk) disable iff (rst)
        (mode_oh[MD_SLEEP] && wake) |=> (mode_oh[MD_HIGH] || mode_oh[MD_MED])); // R7
    AST_SUBSLEEP_RETURN: assert property (@(posedge clk) disable iff (rst)
        (mode_oh[MD_SUBSLEEP] && wake) |=> mode_oh[MD_SUB]); // R7
    AST_LP_HOLD: assert property (@(posedge clk) disable iff (rst)
        (low_pwr && !wake) |=> $stable(mode_oh)); // R10

endmodule

// File: rtl/pwrmode_ctrl.sv
module pwrmode_ctrl
    import pwrmode_pkg::*;
#(
    parameter int SUB_DIV_W = 3,
    parameter int NF_DIV_W  = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 reg_wr,
    input  logic [7:0]           reg_wdata,
    output logic [7:0]           reg_rdata,
    input  logic                 sleep_req,
    input  logic                 stby_sel,
    input  logic                 watch_en,
    input  logic                 direct_ok,
    input  logic                 speed_med,
    input  logic                 wake,
    input  logic                 sub_tick,
    output logic [NUM_MODES-1:0] mode_oh,
    output logic                 cpu_clk_en,
    output logic                 nf_sample
);
    localparam logic [SUB_DIV_W-1:0] SUB_M_SLOW = {SUB_DIV_W{1'b1}};
    localparam logic [SUB_DIV_W-1:0] SUB_M_MID  = SUB_M_SLOW >> 1;
    localparam logic [SUB_DIV_W-1:0] SUB_M_FAST = SUB_M_SLOW >> 2;
    localparam logic [NF_DIV_W-1:0]  NF_M_SLOW  = {NF_DIV_W{1'b1}};
    localparam logic [NF_DIV_W-1:0]  NF_M_FAST  = NF_M_SLOW >> 2;

    ctl_t                 ctl;
    logic                 run_full, run_sub;
    logic [SUB_DIV_W-1:0] sub_mask;
    logic [NF_DIV_W-1:0]  nf_mask;
    logic                 sub_hit, nf_hit;

    pwrmode_regs #(.DW(8)) u_regs (
        .clk   (clk),
        .rst   (rst),
        .wr    (reg_wr),
        .wdata (reg_wdata),
        .rdata (reg_rdata),
        .ctl   (ctl)
    );

    pwrmode_fsm u_fsm (
        .clk         (clk),
        .rst         (rst),
        .xfer_direct (ctl.xfer_direct),
        .low_speed   (ctl.low_speed),
        .sleep_req   (sleep_req),
        .stby_sel    (stby_sel),
        .watch_en    (watch_en),
        .direct_ok   (direct_ok),
        .speed_med   (speed_med),
        .wake        (wake),
        .mode_oh     (mode_oh),
        .run_full    (run_full),
        .run_sub     (run_sub)
    );

    always_comb begin
        if (ctl.sub_sel[1])
            sub_mask = SUB_M_FAST;
        else if (ctl.sub_sel[0])
            sub_mask = SUB_M_MID;
        else
            sub_mask = SUB_M_SLOW;
        nf_mask = ctl.nf_fast ? NF_M_FAST : NF_M_SLOW;
    end

    pwrmode_div #(.W(SUB_DIV_W)) u_sub_div (
        .clk  (clk),
        .rst  (rst),
        .tick (sub_tick),
        .mask (sub_mask),
        .hit  (sub_hit)
    );

    pwrmode_div #(.W(NF_DIV_W)) u_nf_div (
        .clk  (clk),
        .rst  (rst),
        .tick (1'b1),
        .mask (nf_mask),
        .hit  (nf_hit)
    );

    assign cpu_clk_en = run_full || (run_sub && sub_hit);
    assign nf_sample  = nf_hit;

    AST_WR_READBACK: assert property (@(posedge clk) disable iff (rst)
        reg_wr |=> (reg_rdata == ($past(reg_wdata) & 8'hE3))); // R1
    AST_CPU_EN_GATED: assert property (@(posedge clk) disable iff (rst)
        cpu_clk_en |-> (mode_oh[MD_HIGH] || mode_oh[MD_MED] || mode_oh[MD_SUB])); // R11
    AST_NF_SINGLE: assert property (@(posedge clk) disable iff (rst)
        nf_sample |=> !nf_sample); // R12

endmodule

// File: tb/pwrmode_ctrl_test.sv
module pwrmode_ctrl_test;

    localparam int I_HIGH = 0, I_MED = 1, I_SUB = 2, I_SLP = 3,
                   I_SSLP = 4, I_STBY = 5, I_WATCH = 6;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       sleep_req = 1'b0, stby_sel = 1'b0, watch_en = 1'b0;
    logic       direct_ok = 1'b0, speed_med = 1'b0, wake = 1'b0, sub_tick = 1'b0;
    logic [6:0] mode_oh;
    logic       cpu_clk_en, nf_sample;

    int nvec  = 0;
    int nfail = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    pwrmode_ctrl uut (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .sleep_req(sleep_req), .stby_sel(stby_sel),
        .watch_en(watch_en), .direct_ok(direct_ok), .speed_med(speed_med),
        .wake(wake), .sub_tick(sub_tick), .mode_oh(mode_oh),
        .cpu_clk_en(cpu_clk_en), .nf_sample(nf_sample)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        nvec++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic int mode_idx();
        int idx = -1;
        for (int i = 0; i < 7; i++)
            if (mode_oh[i]) idx = (idx == -1) ? i : 99;
        return idx;
    endfunction

    // Independent model of the sleep target, from R4, R5 and R6
    function automatic int model_target(int start, bit dt, bit ls, bit sb, bit we, bit dk);
        if (start == I_SUB) begin
            case ({dt, ls})
                2'b11:   return dk ? I_HIGH : I_SSLP;
                2'b01:   return sb ? I_WATCH : I_SSLP;
                default: return sb ? I_WATCH : (dk ? I_HIGH : I_WATCH);
            endcase
        end
        case ({dt, ls})
            2'b11:   return sb ? I_STBY : (dk ? I_SUB : I_SLP);
            2'b01:   return sb ? (we ? I_WATCH : I_STBY)
                               : ((dk && start == I_HIGH) ? I_SUB : I_SLP);
            default: return sb ? (we ? I_WATCH : I_STBY) : I_SLP;
        endcase
    endfunction

    task automatic step();
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        step();
        rst = 1'b0;
    endtask

    task automatic reg_write(input logic [7:0] v);
        reg_wr = 1'b1;
        reg_wdata = v;
        step();
        reg_wr = 1'b0;
    endtask

    task automatic sleep_pulse(input bit sb, input bit we, input bit dk);
        stby_sel = sb; watch_en = we; direct_ok = dk;
        speed_med = 1'b0;
        sleep_req = 1'b1;
        step();
        sleep_req = 1'b0; stby_sel = 1'b0; watch_en = 1'b0; direct_ok = 1'b0;
    endtask

    task automatic wake_pulse();
        wake = 1'b1;
        step();
        wake = 1'b0;
    endtask

    task automatic count_window(input bit which_cpu, output int n);
        n = 0;
        for (int i = 0; i < 64; i++) begin
            step();
            if (which_cpu ? cpu_clk_en : nf_sample) n++;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            nfail++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
            $finish;
        end
    end

    initial begin
        int n, e, w;
        step();
        do_reset();
        // R2 reset state
        check(mode_idx() == I_HIGH, "R2", mode_idx(), I_HIGH);
        check(reg_rdata == 8'h00, "R1", reg_rdata, 0);
        check(nf_sample == 1'b0, "R12", nf_sample, 0);

        // R1 readback, reserved bits zero
        reg_write(8'hFF);
        check(reg_rdata == 8'hE3, "R1", reg_rdata, 8'hE3);
        reg_write(8'h5D);
        check(reg_rdata == 8'h41, "R1", reg_rdata, 8'h41);

        // R3 speed selection
        do_reset();
        speed_med = 1'b1; step();
        check(mode_idx() == I_MED, "R3", mode_idx(), I_MED);
        speed_med = 1'b0; step();
        check(mode_idx() == I_HIGH, "R3", mode_idx(), I_HIGH);
        wake_pulse();
        check(mode_idx() == I_HIGH, "R10", mode_idx(), I_HIGH);

        // Sleep-target sweep: flags x start state x selects
        for (int f = 0; f < 4; f++) begin
            for (int s = 0; s < 3; s++) begin
                for (int sel = 0; sel < 8; sel++) begin
                    bit dt, ls, sb, we, dk;
                    dt = f[1]; ls = f[0];
                    sb = sel[2]; we = sel[1]; dk = sel[0];
                    do_reset();
                    if (s == I_SUB) begin
                        reg_write(8'hC0);
                        sleep_pulse(1'b0, 1'b0, 1'b1);
                    end
                    reg_write({dt, ls, 6'b0});
                    if (s == I_MED) begin
                        speed_med = 1'b1;
                        step();
                    end
                    check(mode_idx() == s, "R3", mode_idx(), s);
                    e = model_target(s, dt, ls, sb, we, dk);
                    sleep_pulse(sb, we, dk);
                    check(mode_idx() == e, (s == I_SUB) ? "R6" : (sb ? "R4" : "R5"),
                          mode_idx(), e);
                    if (e >= I_SLP) begin
                        check(cpu_clk_en == 1'b0, "R11", cpu_clk_en, 0);
                        sleep_pulse(sb, we, dk);
                        check(mode_idx() == e, "R10", mode_idx(), e);
                    end
                    case (e)
                        I_SLP:   w = s;
                        I_SSLP:  w = I_SUB;
                        I_WATCH: w = ls ? I_SUB : I_HIGH;
                        default: w = e;
                    endcase
                    wake_pulse();
                    check(mode_idx() == w,
                          (e == I_SLP || e == I_SSLP) ? "R7" :
                          (e == I_WATCH) ? "R8" : (e == I_STBY) ? "R9" : "R10",
                          mode_idx(), w);
                end
            end
        end

        // R12 noise strobe rates
        do_reset();
        count_window(1'b0, n);
        check(n == 4, "R12", n, 4);
        reg_write(8'h20);
        count_window(1'b0, n);
        check(n == 16, "R12", n, 16);

        // R11 clock enable in HIGH and MED
        do_reset();
        count_window(1'b1, n);
        check(n == 64, "R11", n, 64);
        speed_med = 1'b1; step();
        count_window(1'b1, n);
        check(n == 64, "R11", n, 64);
        speed_med = 1'b0; step();

        // R11 subclock division ratios
        reg_write(8'hC0);
        sleep_pulse(1'b0, 1'b0, 1'b1);
        check(mode_idx() == I_SUB, "R11", mode_idx(), I_SUB);
        count_window(1'b1, n);
        check(n == 0, "R11", n, 0);
        sub_tick = 1'b1;
        for (int sa = 0; sa < 4; sa++) begin
            int exp_n;
            reg_write({6'b110000, sa[1:0]});
            exp_n = sa[1] ? 32 : (sa[0] ? 16 : 8);
            count_window(1'b1, n);
            check(n == exp_n, "R11", n, exp_n);
        end
        reg_write(8'h40);
        sleep_pulse(1'b0, 1'b0, 1'b0);
        check(mode_idx() == I_SSLP, "R6", mode_idx(), I_SSLP);
        count_window(1'b1, n);
        check(n == 0, "R11", n, 0);
        sub_tick = 1'b0;

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end

endmodule